// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block drives four independent active-high pulse-width modulated lines. Software sets it up through a small word-addressed register port: one write strobe, one write-data word and one read-data word. A shared control word holds a run bit and a two-bit step-clock divider selection for every channel. A separate word per channel holds that channel's period length and its high-time. Both values are counted in divided-clock steps.

Each channel has its own prescaler, which produces one step every 1, 8, 64 or 512 clock cycles. A period counter steps through one period, and a comparator holds the line high for the first part of that period. Writes to a running channel are held in shadow registers. The channel copies them into its working registers only when a period ends, so a period is never cut short or glitched. A channel that is switched off drives low at once, and it begins a clean period when it is switched back on.

Top module: `quad_pwm_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero, `pwm_out` is 0 and `reg_rdata` is 0.
- R2: Word address 0 is the control word. Bit n is the run bit of channel n, and bits 2n+5:2n+4 are the divider code of channel n. Word address 1+n is channel n's setup word: period length in bits 7:0 and high-time in bits 23:16. A read returns the addressed word on `reg_rdata` one cycle after the address is presented. Bits with no field, and addresses 5 to 7, read as zero.
- R3: For a running channel with period length P (1..255), high-time D and step ratio K, the line repeats every P·K clock cycles. It is high for the first min(D,P)·K cycles of each period. It first goes high one cycle after the run bit is written.
- R4: Divider code 0, 1, 2 and 3 gives a step ratio of 1, 8, 64 and 512 clock cycles per step.
- R5: A high-time of 0 holds the line low for the whole period. A high-time greater than or equal to the period length holds it high throughout.
- R6: New period, high-time and divider values written while a channel runs take effect only at the start of that channel's next period.
- R7: A channel whose run bit is 0 drives its line low from the next cycle, and its prescaler and period counter are held at zero. Setting the run bit again starts a fresh period with the high phase first, using the latest written values.
- R8: A period length of 0 keeps a running channel's line low. New values are picked up at every step while the period length is 0.
- R9: The four channels run independently. Each channel's line depends only on its own run bit, divider code and setup word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Word address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_rdata | output | 32 | Registered read data of the addressed word |
| pwm_out | output | 4 | Active-high modulated line per channel |

## Verification
The hardest cases to reach are the period-boundary handovers. One is a setup or divider change that lands in the middle of a long prescaled period. The other is a channel that is switched off during its high phase and then switched back on. The bench writes new values part-way through periods at every divider ratio, including a ratio of 512 with a 16-step period, and runs past the next boundary. It also toggles run bits while a line is high. A behavioural model tracks each channel's shadow and working values and is compared with both outputs on every cycle, so a value picked up one step early or late shows up as a mismatch.

// File: rtl/quad_pwm_pkg.sv
`timescale 1ns/1ps
package quad_pwm_pkg;
  // bits of one prescaler stage (divide by 2**STAGE_W = 8)
  localparam int STAGE_W    = 3;
  // the highest divider code uses this many stages
  localparam int NUM_STAGES = 3;

  typedef enum logic [1:0] {
    DIV_BY_1   = 2'd0,
    DIV_BY_8   = 2'd1,
    DIV_BY_64  = 2'd2,
    DIV_BY_512 = 2'd3
  } step_div_e;
endpackage

// File: rtl/pwm_regfile.sv
`timescale 1ns/1ps
module pwm_regfile #(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          we,
  output logic [DATA_W-1:0]             rdata,
  output logic [NUM_CH-1:0]             run,
  output logic [NUM_CH-1:0][1:0]        div_code,
  output logic [NUM_CH-1:0][TB_W-1:0]   period,
  output logic [NUM_CH-1:0][TB_W-1:0]   high_time
);
  localparam int DIV_LSB  = NUM_CH;       // divider code of channel n at 2n+NUM_CH
  localparam int HIGH_LSB = DATA_W / 2;   // high-time in the upper half-word

  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= '0;
      div_code  <= '0;
      period    <= '0;
      high_time <= '0;
    end else if (we) begin
      if (addr == '0) begin
        run <= wdata[NUM_CH-1:0];
        for (int i = 0; i < NUM_CH; i++)
          div_code[i] <= wdata[DIV_LSB + 2*i +: 2];
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (int'(addr) == i + 1) begin
          period[i]    <= wdata[TB_W-1:0];
          high_time[i] <= wdata[HIGH_LSB +: TB_W];
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == '0) begin
      rd_next[NUM_CH-1:0] = run;
      for (int i = 0; i < NUM_CH; i++)
        rd_next[DIV_LSB + 2*i +: 2] = div_code[i];
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(addr) == i + 1) begin
        rd_next[TB_W-1:0]          = period[i];
        rd_next[HIGH_LSB +: TB_W]  = high_time[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R2: the top byte never carries a field
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:HIGH_LSB+TB_W] == '0);
  // R2: a write to the control word is read back unchanged in its used bits
  p_ctrl_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == '0) |=> (run == $past(wdata[NUM_CH-1:0])));
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler
  import quad_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  step_div_e code,
  output logic      tick
);
  localparam int CNT_W = STAGE_W * NUM_STAGES;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wrap;

  // one all-ones stage field per selected stage: 0, 7, 63 or 511
  always_comb begin
    wrap = '0;
    for (int s = 0; s < NUM_STAGES; s++)
      if (s < int'(code)) wrap[s*STAGE_W +: STAGE_W] = '1;
  end

  assign tick = (cnt == wrap);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end

  // R4: the count never passes the wrap point of the selected ratio
  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= wrap);
  // R7: a cleared prescaler restarts from zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import quad_pwm_pkg::*;
#(
  parameter int TB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [1:0]      sh_div,
  input  logic [TB_W-1:0] sh_period,
  input  logic [TB_W-1:0] sh_high,
  output logic            pwm_q
);
  step_div_e       act_div;
  logic [TB_W-1:0] act_period;
  logic [TB_W-1:0] act_high;
  logic [TB_W-1:0] step;
  logic            tick;
  logic            boundary;

  pwm_prescaler u_presc (
    .clk  (clk),
    .rst  (rst),
    .clr  (!run),
    .code (act_div),
    .tick (tick)
  );

  assign boundary = tick && ((act_period == '0) || (step == act_period - TB_W'(1)));

  // working copies follow the shadow while stopped, else only at a period end
  always_ff @(posedge clk) begin
    if (rst) begin
      act_div    <= DIV_BY_1;
      act_period <= '0;
      act_high   <= '0;
    end else if (!run || boundary) begin
      act_div    <= step_div_e'(sh_div);
      act_period <= sh_period;
      act_high   <= sh_high;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run)   step <= '0;
    else if (boundary) step <= '0;
    else if (tick)     step <= step + TB_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= run && (act_period != '0) && (step < act_high);
  end

  // R7: stopped channel is low on the next cycle
  p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm_q);
  // R3: the step counter stays inside the period
  p_step_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (run && act_period != '0) |-> (step < act_period));
  // R6: working values hold between period ends
  p_hold_active_r6: assert property (@(posedge clk) disable iff (rst)
    (run && !boundary) |=> ($stable(act_period) && $stable(act_high) && $stable(act_div)));
  // R8: zero period length keeps the line low
  p_zero_period_low_r8: assert property (@(posedge clk) disable iff (rst)
    (run && act_period == '0) |=> !pwm_q);
  // R5: high-time at or above the period length keeps the line high
  p_full_high_r5: assert property (@(posedge clk) disable iff (rst)
    (run && act_period != '0 && act_high >= act_period) |=> pwm_q);
endmodule

// File: rtl/quad_pwm_ctrl.sv
`timescale 1ns/1ps
module quad_pwm_ctrl #(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]           run;
  logic [NUM_CH-1:0][1:0]      div_code;
  logic [NUM_CH-1:0][TB_W-1:0] period;
  logic [NUM_CH-1:0][TB_W-1:0] high_time;

  pwm_regfile #(
    .NUM_CH (NUM_CH),
    .TB_W   (TB_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .we        (reg_we),
    .rdata     (reg_rdata),
    .run       (run),
    .div_code  (div_code),
    .period    (period),
    .high_time (high_time)
  );

  // R9: one independent channel per output line
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.TB_W(TB_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .run       (run[c]),
      .sh_div    (div_code[c]),
      .sh_period (period[c]),
      .sh_high   (high_time[c]),
      .pwm_q     (pwm_out[c])
    );
  end

  // R1: lines are low on the first cycle after reset
  p_reset_low_r1: assert property (@(posedge clk) rst |=> (pwm_out == '0));
endmodule

// File: tb/quad_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module quad_pwm_ctrl_tb_top;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_pwm_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  // ---------------- behavioural reference ----------------
  bit [11:0] m_ctrl;
  int        m_per [4];
  int        m_high[4];
  int        a_per [4];
  int        a_high[4];
  int        a_div [4];
  int        pre   [4];
  int        stp   [4];
  bit [3:0]  m_out;
  bit [31:0] m_rd;

  always @(posedge clk) begin : model
    bit [31:0] rd;
    if (rst) begin
      m_ctrl = '0; m_out = '0; m_rd = '0;
      for (int n = 0; n < 4; n++) begin
        m_per[n] = 0; m_high[n] = 0; a_per[n] = 0; a_high[n] = 0;
        a_div[n] = 0; pre[n] = 0; stp[n] = 0;
      end
    end else begin
      rd = '0;
      if (reg_addr == 3'd0) rd = {20'd0, m_ctrl};
      else if (reg_addr <= 3'd4)
        rd = (32'(m_high[reg_addr-1]) << 16) | 32'(m_per[reg_addr-1]);
      m_rd = rd;
      for (int n = 0; n < 4; n++) begin
        if (!m_ctrl[n]) begin
          m_out[n] = 1'b0; pre[n] = 0; stp[n] = 0;
          a_per[n] = m_per[n]; a_high[n] = m_high[n];
          a_div[n] = int'(m_ctrl[4+2*n +: 2]);
        end else begin
          m_out[n] = (a_per[n] != 0) && (stp[n] < a_high[n]);
          if (pre[n] == (1 << (3*a_div[n])) - 1) begin
            pre[n] = 0;
            if (a_per[n] == 0 || stp[n] + 1 >= a_per[n]) begin
              stp[n] = 0;
              a_per[n] = m_per[n]; a_high[n] = m_high[n];
              a_div[n] = int'(m_ctrl[4+2*n +: 2]);
            end else stp[n] = stp[n] + 1;
          end else pre[n] = pre[n] + 1;
        end
      end
      if (reg_we) begin
        if (reg_addr == 3'd0) m_ctrl = reg_wdata[11:0];
        else if (reg_addr <= 3'd4) begin
          m_per [reg_addr-1] = int'(reg_wdata[7:0]);
          m_high[reg_addr-1] = int'(reg_wdata[23:16]);
        end
      end
    end
  end

  // compare both outputs on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pwm_out !== m_out) begin
        fails++;
        $display("FAIL %s pwm_out actual=%b expected=%b at %0t", phase, pwm_out, m_out, $time);
      end
      checks++;
      if (reg_rdata !== m_rd) begin
        fails++;
        $display("FAIL %s reg_rdata actual=%h expected=%h at %0t", phase, reg_rdata, m_rd, $time);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); reg_addr = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg(input int per, input int high);
    return (32'(high) << 16) | 32'(per);
  endfunction

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset state, then read all words back as zero
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 8; a++) rd(3'(a));

    // R3 R5 R9: four channels, ratio 1, different shapes
    phase = "R3/R5/R9";
    wr(3'd1, cfg(20, 5));
    wr(3'd2, cfg(16, 0));
    wr(3'd3, cfg(16, 16));
    wr(3'd4, cfg(18, 200));
    wr(3'd0, 32'h0000_000F);
    idle(100);

    // R2: readback, field masking, unmapped words
    phase = "R2";
    rd(3'd1); rd(3'd0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4); rd(3'd5); rd(3'd7);
    wr(3'd4, cfg(18, 200));

    // R6: change a running channel mid-period
    phase = "R6";
    idle(7);
    wr(3'd1, cfg(12, 10));
    idle(80);

    // R4 R6: switch dividers while running
    phase = "R4/R6";
    wr(3'd2, cfg(16, 3));
    wr(3'd3, cfg(16, 5));
    wr(3'd4, cfg(16, 4));
    wr(3'd0, {20'd0, 2'd3, 2'd2, 2'd1, 2'd0, 4'hF});
    idle(17000);

    // R7: stop a channel in its high phase, then start it again
    phase = "R7";
    wr(3'd0, {20'd0, 2'd3, 2'd2, 2'd1, 2'd0, 4'hE});
    idle(10);
    wr(3'd1, cfg(16, 8));
    wr(3'd0, {20'd0, 2'd3, 2'd2, 2'd1, 2'd0, 4'hF});
    idle(3);
    wr(3'd0, {20'd0, 2'd3, 2'd2, 2'd1, 2'd0, 4'hE});
    wr(3'd0, {20'd0, 2'd3, 2'd2, 2'd1, 2'd1, 4'hF});
    idle(300);

    // R8: zero period length, then recovery
    phase = "R8";
    wr(3'd1, cfg(0, 9));
    idle(300);
    wr(3'd1, cfg(17, 3));
    idle(400);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule